// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element

This block is one cell of a fine-grained SIMD array. It holds four one-bit registers (a north/south transfer register, an east/west transfer register, a carry/borrow register and a shift register) and a small private one-bit-wide RAM. It also contains a one-bit full adder/subtractor. Every cell in an array receives the same 13-bit instruction word, which is the concatenation of five source-select fields. A single instruction therefore loads all four registers and writes the RAM in the same cycle, with every source taken from values held before the clock edge.

The shift register forms a second vertical path. It loads from the cell below and drives the cell above without passing through the ALU. Data can stream through an array while the arithmetic path keeps working. Multi-bit arithmetic is done one bit per step, with the carry or borrow held in the carry register between steps. Operands are brought in bit by bit through the shift register and then written to RAM.

Top module: `bitpe_cell`

## Requirements
- R1: While `rst_n` is low, `ns_o`, `ew_o`, `cmn_o` and the carry register are 0, and the RAM is cleared to 0.
- R2: The instruction fields sit at fixed positions: bits [12:10] select the NS source, [9:7] the EW source, [6:5] the C source, [4:3] the CM source and [2:0] the RAM write source.
- R3: The NS select codes are 0 hold, 1 RAM bit at `addr_i`, 2 `north_i`, 3 `south_i`, 4 ALU sum, 5 EW, 6 CM, 7 zero. The new value appears on `ns_o` after the clock edge.
- R4: The EW select codes are 0 hold, 1 RAM bit, 2 `east_i`, 3 `west_i`, 4 ALU sum, 5 NS, 6 CM, 7 zero. The new value appears on `ew_o` after the clock edge.
- R5: The ALU takes A = NS, B = EW and the C register. The sum is A^B^C. The carry is the majority of A, B and C. The borrow of A-B-C is (~A&B)|(~A&C)|(B&C). C select code 1 loads the carry and code 2 loads the borrow.
- R6: C select code 3 clears the carry register and code 0 holds it.
- R7: The CM select codes are 0 hold, 1 `cms_i`, 2 RAM bit, 3 ALU sum. `cmn_o` always shows the CM register.
- R8: When `we_i` is high, the bit at `addr_i` takes the selected write source: 0 NS, 1 EW, 2 C, 3 CM, 4 sum, 5 carry, 6 borrow, 7 zero. When `we_i` is low, the RAM does not change.
- R9: The RAM read is combinational. A register loading from RAM in the same cycle as a write to that address receives the old bit.
- R10: All five fields act in one cycle on pre-edge values, so NS select 5 together with EW select 5 swaps the two registers.
- R11: A sequence of three instructions per bit, starting with C cleared, adds or subtracts two 8-bit RAM operands. The result is 9 bits: the sum with its carry, or the difference modulo 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 13 | Instruction word (five select fields) |
| we_i | input | 1 | RAM write strobe |
| addr_i | input | ADDR_W | RAM bit address |
| north_i | input | 1 | NS bit of the cell to the north |
| east_i | input | 1 | EW bit of the cell to the east |
| south_i | input | 1 | NS bit of the cell to the south |
| west_i | input | 1 | EW bit of the cell to the west |
| cms_i | input | 1 | Shift-path input from the cell below |
| ns_o | output | 1 | NS register, to north and south neighbours |
| ew_o | output | 1 | EW register, to east and west neighbours |
| cmn_o | output | 1 | CM register, shift-path output upward |

## Verification
The carry register has no port of its own, and the RAM is visible only through moves into registers. So the hardest case to reach is a carry or borrow chain running across many bits, followed by a clear. The stimulus loads 8-bit operands bit by bit through the shift path and runs the three-step add or subtract loop. It stores the final carry in RAM and reads every result bit back out through the shift register, which makes the carry chain and the clear both visible at `cmn_o`. A sweep of all 8192 instruction words with pseudo-random addresses and neighbour bits, each tried with and without a write, checks every output against an arithmetic model of the select tables.

// File: rtl/bitpe_pkg.sv
package bitpe_pkg;

   localparam int NS_FW   = 3;
   localparam int EW_FW   = 3;
   localparam int C_FW    = 2;
   localparam int CM_FW   = 2;
   localparam int WR_FW   = 3;
   localparam int INSTR_W = NS_FW + EW_FW + C_FW + CM_FW + WR_FW;

   typedef enum logic [NS_FW-1:0] {
      NS_HOLD, NS_RAM, NS_NORTH, NS_SOUTH, NS_SUM, NS_EW, NS_CM, NS_ZERO
   } ns_sel_e;

   typedef enum logic [EW_FW-1:0] {
      EW_HOLD, EW_RAM, EW_EAST, EW_WEST, EW_SUM, EW_NS, EW_CM, EW_ZERO
   } ew_sel_e;

   typedef enum logic [C_FW-1:0] {
      C_HOLD, C_CARRY, C_BORROW, C_CLEAR
   } c_sel_e;

   typedef enum logic [CM_FW-1:0] {
      CM_HOLD, CM_SHIFT, CM_RAM, CM_SUM
   } cm_sel_e;

   typedef enum logic [WR_FW-1:0] {
      WR_NS, WR_EW, WR_C, WR_CM, WR_SUM, WR_CARRY, WR_BORROW, WR_ZERO
   } wr_sel_e;

   typedef struct packed {
      ns_sel_e ns;
      ew_sel_e ew;
      c_sel_e  c;
      cm_sel_e cm;
      wr_sel_e wr;
   } instr_t;

endpackage

// File: rtl/bitpe_alu.sv
module bitpe_alu (
   input  logic a_i,
   input  logic b_i,
   input  logic cin_i,
   output logic sum_o,
   output logic carry_o,
   output logic borrow_o
);

   logic diff_ab;

   always_comb begin
      diff_ab  = a_i ^ b_i;
      sum_o    = diff_ab ^ cin_i;
      carry_o  = (a_i & b_i) | (cin_i & diff_ab);
      borrow_o = (~a_i & b_i) | (~diff_ab & cin_i);
   end

endmodule

// File: rtl/bitpe_ram.sv
module bitpe_ram #(
   parameter int ADDR_W         = 5,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wdata_i,
   output logic              rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0] bits_q;

   assign rdata_o = bits_q[addr_i];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bits_q <= '0;
            end else if (we_i) begin
               bits_q[addr_i] <= wdata_i;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we_i) begin
               bits_q[addr_i] <= wdata_i;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bitpe_regs.sv
module bitpe_regs
   import bitpe_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  ns_sel_e ns_sel_i,
   input  ew_sel_e ew_sel_i,
   input  c_sel_e  c_sel_i,
   input  cm_sel_e cm_sel_i,
   input  logic    ram_rd_i,
   input  logic    sum_i,
   input  logic    carry_i,
   input  logic    borrow_i,
   input  logic    north_i,
   input  logic    east_i,
   input  logic    south_i,
   input  logic    west_i,
   input  logic    cms_i,
   output logic    ns_q,
   output logic    ew_q,
   output logic    c_q,
   output logic    cm_q
);

   logic ns_d, ew_d, c_d, cm_d;

   always_comb begin
      unique case (ns_sel_i)
         NS_HOLD:  ns_d = ns_q;
         NS_RAM:   ns_d = ram_rd_i;
         NS_NORTH: ns_d = north_i;
         NS_SOUTH: ns_d = south_i;
         NS_SUM:   ns_d = sum_i;
         NS_EW:    ns_d = ew_q;
         NS_CM:    ns_d = cm_q;
         default:  ns_d = 1'b0;
      endcase
   end

   always_comb begin
      unique case (ew_sel_i)
         EW_HOLD: ew_d = ew_q;
         EW_RAM:  ew_d = ram_rd_i;
         EW_EAST: ew_d = east_i;
         EW_WEST: ew_d = west_i;
         EW_SUM:  ew_d = sum_i;
         EW_NS:   ew_d = ns_q;
         EW_CM:   ew_d = cm_q;
         default: ew_d = 1'b0;
      endcase
   end

   always_comb begin
      unique case (c_sel_i)
         C_HOLD:   c_d = c_q;
         C_CARRY:  c_d = carry_i;
         C_BORROW: c_d = borrow_i;
         default:  c_d = 1'b0;
      endcase
   end

   always_comb begin
      unique case (cm_sel_i)
         CM_HOLD:  cm_d = cm_q;
         CM_SHIFT: cm_d = cms_i;
         CM_RAM:   cm_d = ram_rd_i;
         default:  cm_d = sum_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns_q <= 1'b0;
         ew_q <= 1'b0;
         c_q  <= 1'b0;
         cm_q <= 1'b0;
      end else begin
         ns_q <= ns_d;
         ew_q <= ew_d;
         c_q  <= c_d;
         cm_q <= cm_d;
      end
   end

endmodule

// File: rtl/bitpe_cell.sv
module bitpe_cell
   import bitpe_pkg::*;
#(
   parameter int ADDR_W         = 5,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               we_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               north_i,
   input  logic               east_i,
   input  logic               south_i,
   input  logic               west_i,
   input  logic               cms_i,
   output logic               ns_o,
   output logic               ew_o,
   output logic               cmn_o
);

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
         $error("bitpe_cell: ADDR_W out of supported range");
      end
      if (INSTR_W != 13) begin : g_bad_instr_w
         $error("bitpe_cell: instruction fields must total 13 bits");
      end
   endgenerate

   instr_t ins;
   logic   ram_rd, ram_wd;
   logic   sum, carry, borrow;
   logic   ns_q, ew_q, c_q, cm_q;

   assign ins = instr_t'(instr_i);

   bitpe_alu u_alu (
      .a_i      (ns_q),
      .b_i      (ew_q),
      .cin_i    (c_q),
      .sum_o    (sum),
      .carry_o  (carry),
      .borrow_o (borrow)
   );

   always_comb begin
      unique case (ins.wr)
         WR_NS:     ram_wd = ns_q;
         WR_EW:     ram_wd = ew_q;
         WR_C:      ram_wd = c_q;
         WR_CM:     ram_wd = cm_q;
         WR_SUM:    ram_wd = sum;
         WR_CARRY:  ram_wd = carry;
         WR_BORROW: ram_wd = borrow;
         default:   ram_wd = 1'b0;
      endcase
   end

   bitpe_ram #(
      .ADDR_W         (ADDR_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we_i),
      .addr_i  (addr_i),
      .wdata_i (ram_wd),
      .rdata_o (ram_rd)
   );

   bitpe_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ns_sel_i (ins.ns),
      .ew_sel_i (ins.ew),
      .c_sel_i  (ins.c),
      .cm_sel_i (ins.cm),
      .ram_rd_i (ram_rd),
      .sum_i    (sum),
      .carry_i  (carry),
      .borrow_i (borrow),
      .north_i  (north_i),
      .east_i   (east_i),
      .south_i  (south_i),
      .west_i   (west_i),
      .cms_i    (cms_i),
      .ns_q     (ns_q),
      .ew_q     (ew_q),
      .c_q      (c_q),
      .cm_q     (cm_q)
   );

   assign ns_o  = ns_q;
   assign ew_o  = ew_q;
   assign cmn_o = cm_q;

endmodule

// File: rtl/bitpe_cell_chk.sv
module bitpe_cell_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [12:0] instr_i,
   input logic        cms_i,
   input logic        ns_o,
   input logic        ew_o,
   input logic        cmn_o,
   input logic        c_q
);

   // R7
   cm_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[4:3] == 2'd1) |=> (cmn_o == $past(cms_i)));

   // R6
   c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[6:5] == 2'd3) |=> !c_q);

   // R3
   ns_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[12:10] == 3'd0) |=> $stable(ns_o));

   // R10
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[12:10] == 3'd5 && instr_i[9:7] == 3'd5)
      |=> (ns_o == $past(ew_o) && ew_o == $past(ns_o)));

   // R5
   carry_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[6:5] == 2'd1)
      |=> (c_q == (($past(ns_o) & $past(ew_o)) | ($past(ns_o) & $past(c_q))
                   | ($past(ew_o) & $past(c_q)))));

endmodule

bind bitpe_cell bitpe_cell_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .instr_i (instr_i),
   .cms_i   (cms_i),
   .ns_o    (ns_o),
   .ew_o    (ew_o),
   .cmn_o   (cmn_o),
   .c_q     (c_q)
);

// File: tb/bitpe_cell_test.sv
module bitpe_cell_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] instr_i = '0;
   logic        we_i = 1'b0;
   logic [4:0]  addr_i = '0;
   logic        north_i = 1'b0, east_i = 1'b0, south_i = 1'b0, west_i = 1'b0;
   logic        cms_i = 1'b0;
   logic        ns_o, ew_o, cmn_o;

   int checks = 0;
   int fails  = 0;

   logic        m_ns, m_ew, m_c, m_cm;
   logic [31:0] m_ram;

   always #2 clk = ~clk;

   bitpe_cell uut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .we_i(we_i), .addr_i(addr_i),
      .north_i(north_i), .east_i(east_i), .south_i(south_i), .west_i(west_i),
      .cms_i(cms_i), .ns_o(ns_o), .ew_o(ew_o), .cmn_o(cmn_o)
   );

   function automatic logic [12:0] mk(input int ns, input int ew, input int c,
                                      input int cm, input int wr);
      logic [12:0] r;
      r[12:10] = ns[2:0];
      r[9:7]   = ew[2:0];
      r[6:5]   = c[1:0];
      r[4:3]   = cm[1:0];
      r[2:0]   = wr[2:0];
      return r;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic [12:0] ins, input logic we, input logic [4:0] ad,
                      input logic [3:0] nb, input logic cm_in);
      logic rd, sm, cy, bw, ns_n, ew_n, c_n, cm_n, wd;
      instr_i = ins; we_i = we; addr_i = ad;
      north_i = nb[3]; east_i = nb[2]; south_i = nb[1]; west_i = nb[0];
      cms_i = cm_in;
      rd = m_ram[ad];
      sm = m_ns ^ m_ew ^ m_c;
      cy = (m_ns & m_ew) | (m_ns & m_c) | (m_ew & m_c);
      bw = (~m_ns & m_ew) | (~m_ns & m_c) | (m_ew & m_c);
      case (ins[12:10])
         3'd0: ns_n = m_ns;  3'd1: ns_n = rd;   3'd2: ns_n = nb[3]; 3'd3: ns_n = nb[1];
         3'd4: ns_n = sm;    3'd5: ns_n = m_ew; 3'd6: ns_n = m_cm;  default: ns_n = 1'b0;
      endcase
      case (ins[9:7])
         3'd0: ew_n = m_ew;  3'd1: ew_n = rd;   3'd2: ew_n = nb[2]; 3'd3: ew_n = nb[0];
         3'd4: ew_n = sm;    3'd5: ew_n = m_ns; 3'd6: ew_n = m_cm;  default: ew_n = 1'b0;
      endcase
      case (ins[6:5])
         2'd0: c_n = m_c; 2'd1: c_n = cy; 2'd2: c_n = bw; default: c_n = 1'b0;
      endcase
      case (ins[4:3])
         2'd0: cm_n = m_cm; 2'd1: cm_n = cm_in; 2'd2: cm_n = rd; default: cm_n = sm;
      endcase
      case (ins[2:0])
         3'd0: wd = m_ns; 3'd1: wd = m_ew; 3'd2: wd = m_c;  3'd3: wd = m_cm;
         3'd4: wd = sm;   3'd5: wd = cy;   3'd6: wd = bw;   default: wd = 1'b0;
      endcase
      if (we) m_ram[ad] = wd;
      m_ns = ns_n; m_ew = ew_n; m_c = c_n; m_cm = cm_n;
      @(posedge clk);
      #1;
      chk(ns_o,  m_ns, "R3 NS select");
      chk(ew_o,  m_ew, "R4 EW select");
      chk(cmn_o, m_cm, "R7 CM select");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      m_ns = 0; m_ew = 0; m_c = 0; m_cm = 0; m_ram = '0;
      chk(ns_o, 1'b0, "R1 reset ns");
      chk(ew_o, 1'b0, "R1 reset ew");
      chk(cmn_o, 1'b0, "R1 reset cm");
      rst_n = 1'b1;
   endtask

   // Read a RAM bit out through the shift register
   task automatic peek(input logic [4:0] ad, output logic v);
      cyc(mk(0, 0, 0, 2, 0), 1'b0, ad, 4'b0, 1'b0);
      v = cmn_o;
   endtask

   task automatic arith8(input logic [7:0] a, input logic [7:0] b, input bit sub);
      logic [8:0] got, exp;
      logic       v;
      for (int k = 0; k < 8; k++) begin
         cyc(mk(0, 0, 0, 1, 0), 1'b0, 5'd0, 4'b0, a[k]);
         cyc(mk(0, 0, 0, 0, 3), 1'b1, 5'(k), 4'b0, 1'b0);
         cyc(mk(0, 0, 0, 1, 0), 1'b0, 5'd0, 4'b0, b[k]);
         cyc(mk(0, 0, 0, 0, 3), 1'b1, 5'(8 + k), 4'b0, 1'b0);
      end
      cyc(mk(0, 0, 3, 0, 0), 1'b0, 5'd0, 4'b0, 1'b0);
      for (int i = 0; i < 8; i++) begin
         cyc(mk(1, 0, 0, 0, 0), 1'b0, 5'(i), 4'b0, 1'b0);
         cyc(mk(0, 1, 0, 0, 0), 1'b0, 5'(8 + i), 4'b0, 1'b0);
         cyc(mk(0, 0, sub ? 2 : 1, 0, 4), 1'b1, 5'(16 + i), 4'b0, 1'b0);
      end
      cyc(mk(0, 0, 0, 0, 2), 1'b1, 5'd24, 4'b0, 1'b0);
      for (int k = 0; k < 9; k++) begin
         peek(k < 8 ? 5'(16 + k) : 5'd24, v);
         got[k] = v;
      end
      exp = sub ? 9'((int'(a) - int'(b)) & 511) : 9'(a) + 9'(b);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d)",
                  sub ? "R5 R11 subtract" : "R11 add", got, exp, a, b);
      end
   endtask

   bit done = 0;

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      logic        v;
      m_ns = 0; m_ew = 0; m_c = 0; m_cm = 0; m_ram = '0;
      #1;
      do_reset();

      // R2 field positions, sweep of every instruction word with and without a write
      lf = 16'hACE1;
      for (int i = 0; i < 8192; i++) begin
         for (int w = 0; w < 2; w++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(13'(i), w[0], lf[4:0], lf[8:5], lf[9]);
         end
      end

      do_reset();
      // R1 RAM cleared by reset
      peek(5'd17, v);
      chk(v, 1'b0, "R1 RAM cleared");

      // R10 swap: NS=1 from north, EW=0
      cyc(mk(2, 7, 0, 0, 0), 1'b0, 5'd0, 4'b1000, 1'b0);
      cyc(mk(5, 5, 0, 0, 0), 1'b0, 5'd0, 4'b0, 1'b0);
      chk(ns_o, 1'b0, "R10 swap ns");
      chk(ew_o, 1'b1, "R10 swap ew");

      // R8 write only with strobe: write EW(=1) to addr 9, then strobe-low zero write
      cyc(mk(0, 0, 0, 0, 1), 1'b1, 5'd9, 4'b0, 1'b0);
      cyc(mk(0, 0, 0, 0, 7), 1'b0, 5'd9, 4'b0, 1'b0);
      peek(5'd9, v);
      chk(v, 1'b1, "R8 no write with strobe low");
      // R9 read-before-write in one cycle: NS loads old 1 while zero is written
      cyc(mk(1, 0, 0, 0, 7), 1'b1, 5'd9, 4'b0, 1'b0);
      chk(ns_o, 1'b1, "R9 same-cycle read gets old bit");
      peek(5'd9, v);
      chk(v, 1'b0, "R8 write with strobe high");

      // R11 and R5 arithmetic
      arith8(8'd0,   8'd0,   1'b0);
      arith8(8'd170, 8'd85,  1'b0);
      arith8(8'd200, 8'd100, 1'b0);
      arith8(8'd100, 8'd200, 1'b1);
      arith8(8'd77,  8'd77,  1'b1);
      arith8(8'd0,   8'd1,   1'b1);
      arith8(8'd255, 8'd255, 1'b0);

      // R6 carry left at 1 by 255+255; hold then clear
      cyc(mk(0, 0, 0, 0, 2), 1'b1, 5'd30, 4'b0, 1'b0);
      peek(5'd30, v);
      chk(v, 1'b1, "R6 carry held");
      cyc(mk(0, 0, 3, 0, 0), 1'b0, 5'd0, 4'b0, 1'b0);
      cyc(mk(0, 0, 0, 0, 2), 1'b1, 5'd30, 4'b0, 1'b0);
      peek(5'd30, v);
      chk(v, 1'b0, "R6 carry cleared");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule